// File: doc/BRIEF.md
# Interlaced Vertical Timing Generator

This block derives the vertical control strobes of an interlaced raster: vertical blanking, vertical sync and a field identifier. It runs its own pixel counter, which steps once per pixel clock and restarts at the end of each scan line, and a frame line counter that advances at every line end and restarts after the last line of the frame.

Every edge of every strobe is placed by a programmable (line, pixel) coordinate. The point is reached when both counters equal it, so an edge can fall anywhere along a scan line and not only at a line boundary. Blanking and sync each have an assert point and a release point for field one and another pair for field two. The field identifier has one point where it switches to field one and one where it switches to field two. For a 525-line frame, a typical setting starts field-two blanking halfway along line 263, at pixel 429.

All outputs come from registers on the pixel clock. A strobe therefore changes in the cycle after the counters show its point. The counter values are also exported so that neighbouring logic can share them.

Top module: `vert_timing_gen`

## Requirements
- R1: `pix_cnt` steps by one each clock from 0 up to `line_len`-1 and then returns to 0.
- R2: `line_cnt` steps by one in the clock where `pix_cnt` wraps. Lines are numbered from 1, and after line `frame_lines` the counter returns to 1.
- R3: During an active-low synchronous reset, `pix_cnt` is 0, `line_cnt` is 1, `vblank` and `vsync` are 0, and `field_id` is 0. A value of 0 means field one; a value of 1 means field two.
- R4: `vblank` becomes 1 in the cycle after the counters equal either blanking assert point (field one or field two). It becomes 0 in the cycle after they equal either blanking release point. At all other times it holds its value.
- R5: `vsync` follows the same rule as R4, using the sync assert points and the sync release points.
- R6: An assert or release point may have any pixel value, so a strobe edge can occur in the middle of a line. The edge happens at exactly that pixel position, delayed by one clock.
- R7: When an assert point and a release point of the same strobe are met in the same cycle, the release wins and the strobe is 0 in the next cycle.
- R8: `field_id` becomes 1 in the cycle after the field-two point is met, and becomes 0 in the cycle after the field-one point is met. If both points are met in the same cycle, the field-one point wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_len | input | PIX_W | Pixels per scan line |
| frame_lines | input | LINE_W | Lines per frame |
| blank_on_f1_x | input | PIX_W | Field-one blanking assert, pixel |
| blank_on_f1_y | input | LINE_W | Field-one blanking assert, line |
| blank_off_f1_x | input | PIX_W | Field-one blanking release, pixel |
| blank_off_f1_y | input | LINE_W | Field-one blanking release, line |
| blank_on_f2_x | input | PIX_W | Field-two blanking assert, pixel |
| blank_on_f2_y | input | LINE_W | Field-two blanking assert, line |
| blank_off_f2_x | input | PIX_W | Field-two blanking release, pixel |
| blank_off_f2_y | input | LINE_W | Field-two blanking release, line |
| sync_on_f1_x | input | PIX_W | Field-one sync assert, pixel |
| sync_on_f1_y | input | LINE_W | Field-one sync assert, line |
| sync_off_f1_x | input | PIX_W | Field-one sync release, pixel |
| sync_off_f1_y | input | LINE_W | Field-one sync release, line |
| sync_on_f2_x | input | PIX_W | Field-two sync assert, pixel |
| sync_on_f2_y | input | LINE_W | Field-two sync assert, line |
| sync_off_f2_x | input | PIX_W | Field-two sync release, pixel |
| sync_off_f2_y | input | LINE_W | Field-two sync release, line |
| fid1_x | input | PIX_W | Switch-to-field-one point, pixel |
| fid1_y | input | LINE_W | Switch-to-field-one point, line |
| fid2_x | input | PIX_W | Switch-to-field-two point, pixel |
| fid2_y | input | LINE_W | Switch-to-field-two point, line |
| vblank | output | 1 | Vertical blanking strobe |
| vsync | output | 1 | Vertical sync strobe |
| field_id | output | 1 | Current field (0 = field one, 1 = field two) |
| pix_cnt | output | PIX_W | Pixel counter |
| line_cnt | output | LINE_W | Frame line counter |

## Verification
The bench builds the block with `PIX_W` = 4 and `LINE_W` = 4. It programs a 10-pixel line and a 12-line frame, so one whole frame lasts 120 clocks. This makes the line wrap, the frame wrap and a blanking interval that crosses the frame boundary all reachable within a few hundred cycles. The same small widths let directed runs place an assert point and a release point on the same coordinate, which exercises the priority rules. They also let a run reset the block from the middle of field two.

// File: rtl/vtg_pkg.sv
// Package: vtg_pkg
// Shared constants and types for the vertical timing generator.
// Assumes: strobe and field indices below are used consistently by all users.
package vtg_pkg;
    // Field identifier encoding seen on field_id.
    typedef enum logic {
        FIELD_ONE = 1'b0,
        FIELD_TWO = 1'b1
    } field_e;

    localparam int NUM_FIELDS = 2;  // interlaced: two fields per frame
    localparam int NUM_VSIG   = 2;  // strobes driven by assert/release points
    localparam int SIG_BLANK  = 0;
    localparam int SIG_SYNC   = 1;
endpackage

// File: rtl/vtg_counters.sv
// Module: vtg_counters
// Pixel counter (0 .. line_len-1) and frame line counter (1 .. frame_lines).
// Assumes: line_len >= 1, frame_lines >= 1, and both stay constant outside reset.
module vtg_counters #(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  line_len,
    input  logic [LINE_W-1:0] frame_lines,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt
);
    localparam logic [PIX_W-1:0]  PIX_ONE  = PIX_W'(1);
    localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

    logic line_end;
    logic frame_end;

    // Purpose: flag the last pixel of a line and the last line of a frame.
    always_comb begin
        line_end  = (pix_cnt >= line_len - PIX_ONE);
        frame_end = (line_cnt >= frame_lines);
    end

    // Purpose: advance the pixel counter and wrap it at the end of a line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_cnt <= '0;
        end else if (line_end) begin
            pix_cnt <= '0;
        end else begin
            pix_cnt <= pix_cnt + PIX_ONE;
        end
    end

    // Purpose: advance the line counter at each line end, wrapping to line 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= LINE_ONE;
        end else if (line_end) begin
            if (frame_end) begin
                line_cnt <= LINE_ONE;
            end else begin
                line_cnt <= line_cnt + LINE_ONE;
            end
        end
    end
endmodule

// File: rtl/vtg_point_match.sv
// Module: vtg_point_match
// Combinational detector for one (line, pixel) coordinate.
// Assumes: counters and the programmed point use the same widths.
module vtg_point_match #(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10
) (
    input  logic [PIX_W-1:0]  pix_cnt,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [PIX_W-1:0]  pt_x,
    input  logic [LINE_W-1:0] pt_y,
    output logic              hit
);
    // Purpose: report a hit only when both coordinates agree.
    always_comb begin
        hit = (pix_cnt == pt_x) && (line_cnt == pt_y);
    end
endmodule

// File: rtl/vtg_edge_flop.sv
// Module: vtg_edge_flop
// Set/clear register; clear has priority over set.
// Assumes: set and clr are single-cycle strobes from the point matchers.
module vtg_edge_flop #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Purpose: hold state; clear wins over set; reset loads RST_VAL.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (clr) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end
    end
endmodule

// File: rtl/vert_timing_gen.sv
// Module: vert_timing_gen
// Vertical blanking, vertical sync and field identifier for an interlaced
// raster. Each edge is placed on a (line, pixel) coordinate, per field.
// Assumes: configuration inputs change only while rst_n is low.
module vert_timing_gen #(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10
) (
    input  logic              pix_clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  line_len,
    input  logic [LINE_W-1:0] frame_lines,
    input  logic [PIX_W-1:0]  blank_on_f1_x,
    input  logic [LINE_W-1:0] blank_on_f1_y,
    input  logic [PIX_W-1:0]  blank_off_f1_x,
    input  logic [LINE_W-1:0] blank_off_f1_y,
    input  logic [PIX_W-1:0]  blank_on_f2_x,
    input  logic [LINE_W-1:0] blank_on_f2_y,
    input  logic [PIX_W-1:0]  blank_off_f2_x,
    input  logic [LINE_W-1:0] blank_off_f2_y,
    input  logic [PIX_W-1:0]  sync_on_f1_x,
    input  logic [LINE_W-1:0] sync_on_f1_y,
    input  logic [PIX_W-1:0]  sync_off_f1_x,
    input  logic [LINE_W-1:0] sync_off_f1_y,
    input  logic [PIX_W-1:0]  sync_on_f2_x,
    input  logic [LINE_W-1:0] sync_on_f2_y,
    input  logic [PIX_W-1:0]  sync_off_f2_x,
    input  logic [LINE_W-1:0] sync_off_f2_y,
    input  logic [PIX_W-1:0]  fid1_x,
    input  logic [LINE_W-1:0] fid1_y,
    input  logic [PIX_W-1:0]  fid2_x,
    input  logic [LINE_W-1:0] fid2_y,
    output logic              vblank,
    output logic              vsync,
    output logic              field_id,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt
);
    import vtg_pkg::*;

    // Programmed points gathered per strobe and per field.
    logic [PIX_W-1:0]  on_x  [NUM_VSIG][NUM_FIELDS];
    logic [LINE_W-1:0] on_y  [NUM_VSIG][NUM_FIELDS];
    logic [PIX_W-1:0]  off_x [NUM_VSIG][NUM_FIELDS];
    logic [LINE_W-1:0] off_y [NUM_VSIG][NUM_FIELDS];

    logic [NUM_FIELDS-1:0] on_hit  [NUM_VSIG];
    logic [NUM_FIELDS-1:0] off_hit [NUM_VSIG];
    logic [NUM_VSIG-1:0]   vsig_q;
    logic                  fid1_hit;
    logic                  fid2_hit;
    logic                  fid_q;

    // Purpose: arrange the flat configuration ports into indexed tables.
    always_comb begin
        on_x[SIG_BLANK][0]  = blank_on_f1_x;   on_y[SIG_BLANK][0]  = blank_on_f1_y;
        off_x[SIG_BLANK][0] = blank_off_f1_x;  off_y[SIG_BLANK][0] = blank_off_f1_y;
        on_x[SIG_BLANK][1]  = blank_on_f2_x;   on_y[SIG_BLANK][1]  = blank_on_f2_y;
        off_x[SIG_BLANK][1] = blank_off_f2_x;  off_y[SIG_BLANK][1] = blank_off_f2_y;
        on_x[SIG_SYNC][0]   = sync_on_f1_x;    on_y[SIG_SYNC][0]   = sync_on_f1_y;
        off_x[SIG_SYNC][0]  = sync_off_f1_x;   off_y[SIG_SYNC][0]  = sync_off_f1_y;
        on_x[SIG_SYNC][1]   = sync_on_f2_x;    on_y[SIG_SYNC][1]   = sync_on_f2_y;
        off_x[SIG_SYNC][1]  = sync_off_f2_x;   off_y[SIG_SYNC][1]  = sync_off_f2_y;
    end

    vtg_counters #(
        .PIX_W  (PIX_W),
        .LINE_W (LINE_W)
    ) u_counters (
        .clk         (pix_clk),
        .rst_n       (rst_n),
        .line_len    (line_len),
        .frame_lines (frame_lines),
        .pix_cnt     (pix_cnt),
        .line_cnt    (line_cnt)
    );

    // One assert and one release matcher per field, one register per strobe.
    for (genvar s = 0; s < NUM_VSIG; s++) begin : g_vsig
        for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
            vtg_point_match #(
                .PIX_W  (PIX_W),
                .LINE_W (LINE_W)
            ) u_on_match (
                .pix_cnt  (pix_cnt),
                .line_cnt (line_cnt),
                .pt_x     (on_x[s][f]),
                .pt_y     (on_y[s][f]),
                .hit      (on_hit[s][f])
            );

            vtg_point_match #(
                .PIX_W  (PIX_W),
                .LINE_W (LINE_W)
            ) u_off_match (
                .pix_cnt  (pix_cnt),
                .line_cnt (line_cnt),
                .pt_x     (off_x[s][f]),
                .pt_y     (off_y[s][f]),
                .hit      (off_hit[s][f])
            );
        end

        vtg_edge_flop #(
            .RST_VAL (1'b0)
        ) u_strobe (
            .clk   (pix_clk),
            .rst_n (rst_n),
            .set   (|on_hit[s]),
            .clr   (|off_hit[s]),
            .q     (vsig_q[s])
        );
    end

    vtg_point_match #(
        .PIX_W  (PIX_W),
        .LINE_W (LINE_W)
    ) u_fid1_match (
        .pix_cnt  (pix_cnt),
        .line_cnt (line_cnt),
        .pt_x     (fid1_x),
        .pt_y     (fid1_y),
        .hit      (fid1_hit)
    );

    vtg_point_match #(
        .PIX_W  (PIX_W),
        .LINE_W (LINE_W)
    ) u_fid2_match (
        .pix_cnt  (pix_cnt),
        .line_cnt (line_cnt),
        .pt_x     (fid2_x),
        .pt_y     (fid2_y),
        .hit      (fid2_hit)
    );

    // Field register: set means field two, so the field-one point (clear) wins.
    vtg_edge_flop #(
        .RST_VAL (FIELD_ONE)
    ) u_field (
        .clk   (pix_clk),
        .rst_n (rst_n),
        .set   (fid2_hit),
        .clr   (fid1_hit),
        .q     (fid_q)
    );

    // Purpose: drive the strobe outputs from their registers.
    always_comb begin
        vblank   = vsig_q[SIG_BLANK];
        vsync    = vsig_q[SIG_SYNC];
        field_id = fid_q;
    end
endmodule

// File: rtl/vtg_checker.sv
// Module: vtg_checker
// Concurrent properties for vert_timing_gen, attached with bind.
// Assumes: configuration is stable outside reset.
module vtg_checker #(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PIX_W-1:0]  line_len,
    input logic [LINE_W-1:0] frame_lines,
    input logic [PIX_W-1:0]  b_on1_x, b_off1_x, b_on2_x, b_off2_x,
    input logic [LINE_W-1:0] b_on1_y, b_off1_y, b_on2_y, b_off2_y,
    input logic [PIX_W-1:0]  s_on1_x, s_off1_x, s_on2_x, s_off2_x,
    input logic [LINE_W-1:0] s_on1_y, s_off1_y, s_on2_y, s_off2_y,
    input logic [PIX_W-1:0]  f1_x, f2_x,
    input logic [LINE_W-1:0] f1_y, f2_y,
    input logic              vblank,
    input logic              vsync,
    input logic              field_id,
    input logic [PIX_W-1:0]  pix_cnt,
    input logic [LINE_W-1:0] line_cnt
);
    logic last_pix;
    logic b_start, b_stop, s_start, s_stop, f1_hit, f2_hit;

    // Purpose: independent point detection from the exported counters.
    always_comb begin
        last_pix = (pix_cnt == line_len - PIX_W'(1));
        b_start  = (pix_cnt == b_on1_x  && line_cnt == b_on1_y)  || (pix_cnt == b_on2_x  && line_cnt == b_on2_y);
        b_stop   = (pix_cnt == b_off1_x && line_cnt == b_off1_y) || (pix_cnt == b_off2_x && line_cnt == b_off2_y);
        s_start  = (pix_cnt == s_on1_x  && line_cnt == s_on1_y)  || (pix_cnt == s_on2_x  && line_cnt == s_on2_y);
        s_stop   = (pix_cnt == s_off1_x && line_cnt == s_off1_y) || (pix_cnt == s_off2_x && line_cnt == s_off2_y);
        f1_hit   = (pix_cnt == f1_x && line_cnt == f1_y);
        f2_hit   = (pix_cnt == f2_x && line_cnt == f2_y);
    end

    p_pix_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt < line_len - PIX_W'(1)) |=> (pix_cnt == $past(pix_cnt) + PIX_W'(1)));
    p_pix_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        last_pix |=> (pix_cnt == '0));
    p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (last_pix && line_cnt < frame_lines) |=> (line_cnt == $past(line_cnt) + LINE_W'(1)));
    p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (last_pix && line_cnt == frame_lines) |=> (line_cnt == LINE_W'(1)));
    p_reset_state_r3: assert property (@(posedge clk)
        !rst_n |=> (pix_cnt == '0 && line_cnt == LINE_W'(1) && !vblank && !vsync && !field_id));
    p_blank_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_start && !b_stop) |=> vblank);
    p_blank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_start && !b_stop) |=> $stable(vblank));
    p_sync_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_start && !s_stop) |=> vsync);
    p_sync_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_start && !s_stop) |=> $stable(vsync));
    p_blank_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        b_stop |=> !vblank);
    p_sync_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_stop |=> !vsync);
    p_field_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        f1_hit |=> !field_id);
    p_field_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (f2_hit && !f1_hit) |=> field_id);
    p_field_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!f1_hit && !f2_hit) |=> $stable(field_id));
endmodule

bind vert_timing_gen vtg_checker #(
    .PIX_W  (PIX_W),
    .LINE_W (LINE_W)
) u_vtg_chk (
    .clk         (pix_clk),
    .rst_n       (rst_n),
    .line_len    (line_len),
    .frame_lines (frame_lines),
    .b_on1_x     (blank_on_f1_x),  .b_on1_y  (blank_on_f1_y),
    .b_off1_x    (blank_off_f1_x), .b_off1_y (blank_off_f1_y),
    .b_on2_x     (blank_on_f2_x),  .b_on2_y  (blank_on_f2_y),
    .b_off2_x    (blank_off_f2_x), .b_off2_y (blank_off_f2_y),
    .s_on1_x     (sync_on_f1_x),   .s_on1_y  (sync_on_f1_y),
    .s_off1_x    (sync_off_f1_x),  .s_off1_y (sync_off_f1_y),
    .s_on2_x     (sync_on_f2_x),   .s_on2_y  (sync_on_f2_y),
    .s_off2_x    (sync_off_f2_x),  .s_off2_y (sync_off_f2_y),
    .f1_x        (fid1_x),         .f1_y     (fid1_y),
    .f2_x        (fid2_x),         .f2_y     (fid2_y),
    .vblank      (vblank),
    .vsync       (vsync),
    .field_id    (field_id),
    .pix_cnt     (pix_cnt),
    .line_cnt    (line_cnt)
);

// File: tb/test_vert_timing_gen.sv
// Bench for vert_timing_gen: table-driven frame walk, then directed cases.
module test_vert_timing_gen;
    localparam int PIX_W  = 4;
    localparam int LINE_W = 4;
    localparam int NVEC   = 19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PIX_W-1:0]  line_len = 4'd10;
    logic [LINE_W-1:0] frame_lines = 4'd12;
    logic [PIX_W-1:0]  bo1x, bf1x, bo2x, bf2x, so1x, sf1x, so2x, sf2x, f1x, f2x;
    logic [LINE_W-1:0] bo1y, bf1y, bo2y, bf2y, so1y, sf1y, so2y, sf2y, f1y, f2y;
    logic              vblank, vsync, field_id;
    logic [PIX_W-1:0]  pix_cnt;
    logic [LINE_W-1:0] line_cnt;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    vert_timing_gen #(.PIX_W(PIX_W), .LINE_W(LINE_W)) i_vert_timing_gen (
        .pix_clk(clk), .rst_n(rst_n), .line_len(line_len), .frame_lines(frame_lines),
        .blank_on_f1_x(bo1x), .blank_on_f1_y(bo1y), .blank_off_f1_x(bf1x), .blank_off_f1_y(bf1y),
        .blank_on_f2_x(bo2x), .blank_on_f2_y(bo2y), .blank_off_f2_x(bf2x), .blank_off_f2_y(bf2y),
        .sync_on_f1_x(so1x), .sync_on_f1_y(so1y), .sync_off_f1_x(sf1x), .sync_off_f1_y(sf1y),
        .sync_on_f2_x(so2x), .sync_on_f2_y(so2y), .sync_off_f2_x(sf2x), .sync_off_f2_y(sf2y),
        .fid1_x(f1x), .fid1_y(f1y), .fid2_x(f2x), .fid2_y(f2y),
        .vblank(vblank), .vsync(vsync), .field_id(field_id),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt)
    );

    // Entry: {line, pixel, vblank, vsync, field_id} expected at that counter position.
    localparam logic [10:0] VEC [NVEC] = '{
        {4'd1,  4'd0, 1'b0, 1'b0, 1'b0},
        {4'd1,  4'd3, 1'b0, 1'b0, 1'b0},
        {4'd1,  4'd4, 1'b0, 1'b1, 1'b0},
        {4'd1,  4'd8, 1'b0, 1'b1, 1'b0},
        {4'd1,  4'd9, 1'b0, 1'b0, 1'b0},
        {4'd6,  4'd5, 1'b0, 1'b0, 1'b0},
        {4'd6,  4'd6, 1'b1, 1'b0, 1'b0},
        {4'd7,  4'd1, 1'b1, 1'b1, 1'b0},
        {4'd7,  4'd2, 1'b1, 1'b1, 1'b0},
        {4'd7,  4'd3, 1'b1, 1'b1, 1'b1},
        {4'd7,  4'd9, 1'b1, 1'b1, 1'b1},
        {4'd8,  4'd0, 1'b1, 1'b0, 1'b1},
        {4'd8,  4'd3, 1'b1, 1'b0, 1'b1},
        {4'd8,  4'd4, 1'b0, 1'b0, 1'b1},
        {4'd12, 4'd8, 1'b1, 1'b0, 1'b1},
        {4'd1,  4'd0, 1'b1, 1'b0, 1'b1},
        {4'd1,  4'd2, 1'b1, 1'b0, 1'b0},
        {4'd1,  4'd4, 1'b1, 1'b1, 1'b0},
        {4'd2,  4'd7, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic base_config();
        bo1x = 4'd7; bo1y = 4'd12; bf1x = 4'd6; bf1y = 4'd2;
        bo2x = 4'd5; bo2y = 4'd6;  bf2x = 4'd3; bf2y = 4'd8;
        so1x = 4'd3; so1y = 4'd1;  sf1x = 4'd8; sf1y = 4'd1;
        so2x = 4'd0; so2y = 4'd7;  sf2x = 4'd9; sf2y = 4'd7;
        f1x  = 4'd1; f1y  = 4'd1;  f2x  = 4'd2; f2y  = 4'd7;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Waits at falling edges until the counters show (y, x).
    task automatic wait_pos(input int y, input int x);
        for (int k = 0; k < 400; k++) begin
            if (int'(line_cnt) == y && int'(pix_cnt) == x) return;
            @(negedge clk);
        end
        check($sformatf("R1 position %0d,%0d not reached", y, x), 0, 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        base_config();
        do_reset();

        // Table walk over one frame plus its wrap (R4, R5, R6, R8).
        for (int i = 0; i < NVEC; i++) begin
            wait_pos(int'(VEC[i][10:7]), int'(VEC[i][6:3]));
            check($sformatf("R4 vblank vec %0d", i), int'(vblank),   int'(VEC[i][2]));
            check($sformatf("R5/R6 vsync vec %0d", i), int'(vsync),  int'(VEC[i][1]));
            check($sformatf("R8 field_id vec %0d", i), int'(field_id), int'(VEC[i][0]));
        end

        // R1: pixel wrap at line_len-1; R2: line step on that wrap.
        wait_pos(3, 9);
        @(negedge clk);
        check("R1 pix wrap", int'(pix_cnt), 0);
        check("R2 line step", int'(line_cnt), 4);

        // R2: frame wrap from line 12 to line 1.
        wait_pos(12, 9);
        @(negedge clk);
        check("R2 frame wrap", int'(line_cnt), 1);

        // R3: reset from mid field two.
        wait_pos(7, 5);
        check("R3 pre-reset field", int'(field_id), 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R3 reset pix", int'(pix_cnt), 0);
        check("R3 reset line", int'(line_cnt), 1);
        check("R3 reset vblank", int'(vblank), 0);
        check("R3 reset vsync", int'(vsync), 0);
        check("R3 reset field", int'(field_id), 0);

        // R7/R8: coincident assert and release points; release side wins.
        base_config();
        bf2x = 4'd5; bf2y = 4'd6;   // blank release on its field-two assert point
        sf2x = 4'd0; sf2y = 4'd7;   // sync release on its field-two assert point
        f1x  = 4'd2; f1y  = 4'd7;   // field-one point on the field-two point
        do_reset();
        wait_pos(6, 6);
        check("R7 blank stop wins", int'(vblank), 0);
        wait_pos(7, 1);
        check("R7 sync stop wins", int'(vsync), 0);
        wait_pos(7, 3);
        check("R8 field one wins", int'(field_id), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule